// File: doc/BRIEF.md
# Two-Operator FM Voice with Modulator Feedback

This block computes one sample of a two-operator frequency-modulation voice for each accepted input beat. The first operator is a modulator that feeds its own recent output back into its phase. The second is a carrier whose phase is offset by the modulator's result. Each operator keeps a phase accumulator that steps by a per-operator increment. The step can be scaled by a shared vibrato value. The top bits of the phase, plus any offset, address a computed log-domain sine. The envelope attenuation is added to that log value, and the sum is turned into a signed linear amplitude.

The input side is a valid/ready stream. One beat carries the increments, the vibrato value, the per-operator vibrato enables, the feedback depth and both attenuations. The output side is a valid/ready stream of carrier samples. A result sits in a single output register. While that register holds a sample the sink has not taken, `in_ready` is low, so no new beat is accepted. The block accepts a new beat in the same cycle as the sink takes the old sample. Envelope shaping and register decoding happen elsewhere.

Top module: `fmpair_voice`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1. Reset clears both phases and the stored modulator and carrier history, so the first sample after reset starts from zero state.
- R2: A beat transfers when `in_valid` and `in_ready` are both 1. `in_ready` equals `!out_valid || out_ready`. After a transfer, `out_valid` is 1 in the next cycle. While `out_valid` is 1 and `out_ready` is 0, `out_sample` does not change.
- R3: On each transfer, each 18-bit phase adds its 12-bit increment, modulo 2^18. The operator's 8-bit table index is bit 17 down to bit 10 of the updated phase.
- R4: When the operator's bit of `pm_en` is set (bit 0 for the modulator, bit 1 for the carrier), the phase adds (increment × `lfo`) >> 8 instead of the increment.
- R5: For an 8-bit index i, let q = i mod 64. If bit 6 of i is set, q is replaced by 63 − q. The log attenuation is (63 − q) >> 1. The sign is negative when bit 7 of i is set.
- R6: With a = log attenuation + operator attenuation, the magnitude is ((16 − (a mod 8)) × 256) >> (a / 8). The new operator output is ± that magnitude, so it lies within ±4096.
- R7: An operator whose attenuation + 1 is at least 127 gives 0 as its new output. Its history still updates with that 0.
- R8: When `fb_level` is nonzero, the modulator index is its phase index plus (stored feedback >>> (10 − `fb_level`)), modulo 256. When `fb_level` is 0, no offset is added.
- R9: On each transfer, the modulator's new feedback value is (previous raw output + new raw output) >>> 1. The new raw output then becomes the previous one.
- R10: The carrier index is its phase index plus (new modulator feedback value >>> 2), modulo 256.
- R11: The sample returned is (previous returned sample + new carrier output) >>> 1. That value is kept as the history for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| mod_inc | input | 12 | Modulator phase increment |
| car_inc | input | 12 | Carrier phase increment |
| lfo | input | 9 | Vibrato multiplier, 256 is unity |
| pm_en | input | 2 | Vibrato enable, bit 0 modulator, bit 1 carrier |
| fb_level | input | 3 | Modulator feedback depth, 0 is off |
| mod_att | input | 7 | Modulator envelope attenuation |
| car_att | input | 7 | Carrier envelope attenuation |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Sink takes the sample |
| out_sample | output | 14 | Signed carrier sample |

## Verification
Every piece of internal state feeds the next sample. A wrong phase, feedback register or carrier history therefore shows up as a wrong `out_sample` on the transfer that follows, one cycle after it is accepted, and the error keeps propagating after that. A bench model tracks the same state with plain integer arithmetic and compares the outputs each cycle. A stall-handling fault shows at once as `out_valid` or `in_ready` disagreeing with the handshake rule.

// File: rtl/fmpair_pkg.sv
package fmpair_pkg;
  localparam int TBL_W    = 8;
  localparam int AMP_BITS = 12;
  localparam int SAMP_W   = AMP_BITS + 2;
  localparam int SH_4PI   = AMP_BITS - TBL_W - 1;
  localparam int SH_8PI   = AMP_BITS - TBL_W - 2;

  typedef logic signed [SAMP_W-1:0] samp_t;
  typedef logic [TBL_W-1:0]         tidx_t;

  function automatic samp_t avg2(samp_t a, samp_t b);
    logic signed [SAMP_W:0] s;
    s = {a[SAMP_W-1], a} + {b[SAMP_W-1], b};
    return s[SAMP_W:1];
  endfunction
endpackage

// File: rtl/fmpair_phase.sv
module fmpair_phase #(
  parameter int PHASE_W  = 18,
  parameter int INC_W    = 12,
  parameter int LFO_W    = 9,
  parameter int PM_SHIFT = 8,
  parameter int IDX_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [INC_W-1:0]   inc,
  input  logic [LFO_W-1:0]   lfo,
  input  logic               pm_en,
  output logic [IDX_W-1:0]   idx
);
  localparam int PROD_W = INC_W + LFO_W;

  logic [PROD_W-1:0]  prod;
  logic [PHASE_W-1:0] step, phase_q, phase_nxt;

  assign prod      = {{LFO_W{1'b0}}, inc} * {{INC_W{1'b0}}, lfo};
  assign step      = pm_en ? PHASE_W'(prod >> PM_SHIFT) : PHASE_W'(inc);
  assign phase_nxt = phase_q + step;
  assign idx       = phase_nxt[PHASE_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n)   phase_q <= '0;
    else if (adv) phase_q <= phase_nxt;
  end

  // R3
  phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(phase_q));
endmodule

// File: rtl/fmpair_oper.sv
module fmpair_oper
  import fmpair_pkg::*;
#(
  parameter int ATT_W    = 7,
  parameter int MUTE_LVL = 127
) (
  input  tidx_t             idx,
  input  logic [ATT_W-1:0]  att,
  output samp_t             samp
);
  localparam int QB   = TBL_W - 2;
  localparam int LA_W = QB - 1;
  localparam int AW   = ((LA_W > ATT_W) ? LA_W : ATT_W) + 1;

  logic [QB-1:0]        q;
  logic [LA_W-1:0]      la;
  logic [AW-1:0]        a;
  logic [4:0]           mant;
  logic [AMP_BITS:0]    mag;
  logic                 muted;

  assign q     = idx[TBL_W-2] ? ~idx[QB-1:0] : idx[QB-1:0];
  assign la    = ~q[QB-1:1];
  assign a     = AW'(la) + AW'(att);
  assign mant  = 5'd16 - {2'b00, a[2:0]};
  assign mag   = {mant, {(AMP_BITS-4){1'b0}}} >> a[AW-1:3];
  assign muted = ((ATT_W+1)'(att) + (ATT_W+1)'(1)) >= (ATT_W+1)'(MUTE_LVL);

  always_comb begin
    if (muted)               samp = '0;
    else if (idx[TBL_W-1])   samp = -$signed({1'b0, mag});
    else                     samp = $signed({1'b0, mag});
  end
endmodule

// File: rtl/fmpair_voice.sv
module fmpair_voice
  import fmpair_pkg::*;
#(
  parameter int PHASE_W  = 18,
  parameter int INC_W    = 12,
  parameter int LFO_W    = 9,
  parameter int PM_SHIFT = 8,
  parameter int ATT_W    = 7,
  parameter int MUTE_LVL = 127,
  parameter int FB_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INC_W-1:0]     mod_inc,
  input  logic [INC_W-1:0]     car_inc,
  input  logic [LFO_W-1:0]     lfo,
  input  logic [1:0]           pm_en,
  input  logic [FB_W-1:0]      fb_level,
  input  logic [ATT_W-1:0]     mod_att,
  input  logic [ATT_W-1:0]     car_att,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SAMP_W-1:0]    out_sample
);
  localparam int FB_MAX = (1 << FB_W) - 1;
  localparam int SHA_W  = 5;

  logic             take;
  logic [INC_W-1:0] inc_arr [2];
  tidx_t            ph_idx  [2];
  tidx_t            mod_idx, car_idx;
  logic [SHA_W-1:0] fb_sh;
  samp_t            m_new, m_avg, c_new, c_avg;
  samp_t            m_prev_q, m_fb_q, c_hist_q;

  assign in_ready   = !out_valid || out_ready;
  assign take       = in_valid && in_ready;
  assign inc_arr[0] = mod_inc;
  assign inc_arr[1] = car_inc;

  for (genvar g = 0; g < 2; g++) begin : g_ph
    fmpair_phase #(
      .PHASE_W(PHASE_W), .INC_W(INC_W), .LFO_W(LFO_W),
      .PM_SHIFT(PM_SHIFT), .IDX_W(TBL_W)
    ) u_ph (
      .clk(clk), .rst_n(rst_n), .adv(take), .inc(inc_arr[g]),
      .lfo(lfo), .pm_en(pm_en[g]), .idx(ph_idx[g])
    );
  end

  // modulator: self feedback scaled to two periods, trimmed by depth
  assign fb_sh   = SHA_W'(SH_4PI + FB_MAX) - SHA_W'(fb_level);
  assign mod_idx = (fb_level == '0) ? ph_idx[0]
                                    : ph_idx[0] + TBL_W'(m_fb_q >>> fb_sh);

  fmpair_oper #(.ATT_W(ATT_W), .MUTE_LVL(MUTE_LVL)) u_mod (
    .idx(mod_idx), .att(mod_att), .samp(m_new)
  );

  assign m_avg   = avg2(m_prev_q, m_new);

  // carrier: modulator result scaled to four periods
  assign car_idx = ph_idx[1] + TBL_W'(m_avg >>> SH_8PI);

  fmpair_oper #(.ATT_W(ATT_W), .MUTE_LVL(MUTE_LVL)) u_car (
    .idx(car_idx), .att(car_att), .samp(c_new)
  );

  assign c_avg   = avg2(c_hist_q, c_new);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_prev_q   <= '0;
      m_fb_q     <= '0;
      c_hist_q   <= '0;
      out_sample <= '0;
      out_valid  <= 1'b0;
    end else if (take) begin
      m_prev_q   <= m_new;
      m_fb_q     <= m_avg;
      c_hist_q   <= c_avg;
      out_sample <= c_avg;
      out_valid  <= 1'b1;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6
  amp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_sample) <= 4096 && $signed(out_sample) >= -4096));

  // R11
  hist_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (c_hist_q == $signed(out_sample)));
endmodule

// File: tb/fmpair_voice_bench.sv
module fmpair_voice_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] mod_inc = '0, car_inc = '0;
  logic [8:0]  lfo = '0;
  logic [1:0]  pm_en = '0;
  logic [2:0]  fb_level = '0;
  logic [6:0]  mod_att = '0, car_att = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [13:0] out_sample;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int mph = 0, cph = 0, mprev = 0, mfb = 0, cavg = 0;
  int exp_valid = 0, exp_sample = 0;

  always #5 clk = ~clk;

  fmpair_voice u_fmpair_voice (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mod_inc(mod_inc), .car_inc(car_inc), .lfo(lfo), .pm_en(pm_en),
    .fb_level(fb_level), .mod_att(mod_att), .car_att(car_att),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  task automatic chk(string tag, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic int op(int idx, int att);
    int q, la, a, mag;
    if (att + 1 >= 127) return 0;
    q = idx % 64;
    if (((idx / 64) % 2) == 1) q = 63 - q;
    la  = (63 - q) / 2;
    a   = la + att;
    mag = ((16 - a % 8) * 256) >> (a / 8);
    return (idx >= 128) ? -mag : mag;
  endfunction

  task automatic model_take();
    int sm, sc, midx, cidx, off, mn, navg, cn;
    sm = pm_en[0] ? ((int'(mod_inc) * int'(lfo)) >> 8) : int'(mod_inc);
    sc = pm_en[1] ? ((int'(car_inc) * int'(lfo)) >> 8) : int'(car_inc);
    mph  = (mph + sm) % 262144;
    cph  = (cph + sc) % 262144;
    midx = mph >> 10;
    cidx = cph >> 10;
    off  = (fb_level == 0) ? 0 : (mfb >>> (10 - int'(fb_level)));
    mn   = op((midx + off) & 255, int'(mod_att));
    navg = (mprev + mn) >>> 1;
    mprev = mn;
    mfb  = navg;
    cn   = op((cidx + (navg >>> 2)) & 255, int'(car_att));
    cavg = (cavg + cn) >>> 1;
    exp_sample = cavg;
    exp_valid  = 1;
  endtask

  // mode: 0 plain, 1 vibrato, 2 table, 3 mute, 4 feedback, 5 mixed, 6 stall
  task automatic run(string tag, int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({tag, " R2 valid"}, int'(out_valid), exp_valid);
      if (exp_valid != 0) chk({tag, " sample"}, int'($signed(out_sample)), exp_sample);
      in_valid  = (mode >= 5) ? 1'($urandom_range(0, 1)) : 1'b1;
      out_ready = (mode == 6) ? 1'($urandom_range(0, 1)) : 1'b1;
      mod_inc   = 12'($urandom_range(0, 4095));
      car_inc   = 12'($urandom_range(0, 4095));
      lfo       = 9'($urandom_range(0, 511));
      pm_en     = (mode == 1 || mode >= 5) ? 2'($urandom_range(0, 3)) : 2'b00;
      fb_level  = (mode == 4) ? 3'($urandom_range(1, 7))
                : (mode >= 5) ? 3'($urandom_range(0, 7)) : 3'd0;
      case (mode)
        0, 1:    begin mod_att = 7'($urandom_range(0, 40));   car_att = 7'($urandom_range(0, 40)); end
        3:       begin mod_att = 7'($urandom_range(120, 127)); car_att = 7'($urandom_range(120, 127)); end
        default: begin mod_att = 7'($urandom_range(0, 127)); car_att = 7'($urandom_range(0, 127)); end
      endcase
      #1;
      chk("R2 in_ready", int'(in_ready), int'((exp_valid == 0) || out_ready));
      if (in_valid && ((exp_valid == 0) || out_ready)) model_take();
      else if (out_ready) exp_valid = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    run("R3", 300, 0);
    run("R4", 300, 1);
    run("R5 R6", 400, 2);
    run("R7", 300, 3);
    run("R8 R9", 400, 4);
    run("R10 R11", 400, 5);
    run("R2 stall", 500, 6);
    @(negedge clk);
    in_valid = 1'b0;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule